// File: doc/BRIEF.md
# Multiplexed Address/Data Pseudo-Static RAM Controller

This block sits on the host side of a 16-bit pseudo-static RAM whose lower sixteen address bits travel over the same pins as the data. A client hands it one request at a time: a read or a write, a 24-bit word address, 16 bits of write data, two byte-lane enables and a flag that steers the cycle to the memory's configuration registers instead of its array. The controller turns that request into a fixed asynchronous pin sequence and reports completion with a single-cycle done pulse. Read data is returned on a held output.

Each access walks through five timed phases. First comes an address phase, with the chip selected, the address-valid strobe low and the lower address on the shared bus. Next is a latch cycle, in which address-valid rises while the address is still driven. Then comes a data phase, in which write enable or output enable is active for a parameterised number of clocks. A recovery phase deselects the chip, and a one-cycle done state follows. On reads the controller stops driving the shared bus one cycle before it turns on output enable. The upper eight address bits sit on their own pins for the whole access. The memory clock pin stays low, since only asynchronous cycles are issued.

The address, data and recovery phase lengths are parameters counted in controller clocks, each at least one. A request that arrives while an access is in flight is dropped. The client waits for done before it issues the next request.

Top module: `amux_psram_ctrl`

## Requirements
- R1: While the address-valid strobe (`mem_adv_n`) is low, the chip select is low and the shared bus drives `req_addr[15:0]`. This address phase lasts `ADDR_CYC` clocks. `mem_addr_hi` carries `req_addr[23:16]` and stays unchanged while the chip is selected.
- R2: `mem_adv_n` rises while the chip is still selected, and the bus keeps driving the same address value in the cycle of that rise.
- R3: On a write, `mem_we_n` is low for exactly `DATA_CYC` clocks while the bus drives `req_wdata`. `mem_lb_n` is the inverse of `req_be[0]` (lane DQ[7:0]) and `mem_ub_n` is the inverse of `req_be[1]` (lane DQ[15:8]). A lane with its enable at 0 is left unchanged in the memory.
- R4: On a read, the bus is released for one clock. After that, `mem_oe_n` is low for exactly `DATA_CYC` clocks with the bus still released. `mem_oe_n` and `mem_we_n` are never low together, and neither is low while `mem_adv_n` is low.
- R5: Read data is captured from `mem_adq_i` on the last clock that `mem_oe_n` is low. It is presented on `rsp_rdata` and held until the next read completes.
- R6: When `req_cfg` is 1, `mem_cre` is high and steady for the whole time the chip is selected. A configuration write loads the register with the 24-bit request address, taken from the address pins. A configuration read returns the register contents.
- R7: After the data phase, all strobes and the chip select stay high for `REC_CYC` clocks. `rsp_done` then rises `ADDR_CYC+DATA_CYC+REC_CYC+1` clock edges after the edge that accepted a write, or one edge later for a read. It stays high for exactly one cycle, with the chip deselected.
- R8: `req_valid` is sampled only while the controller is idle. A request raised during an access starts no second access and raises no extra done.
- R9: After reset and between accesses, all strobes are high, `mem_adq_oe` is 0 and `rsp_done` is 0. `mem_clk` is held low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cfg | input | 1 | Target the configuration registers |
| req_addr | input | 24 | Word address (configuration value on config writes) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = low byte |
| rsp_rdata | output | 16 | Last read result |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_clk | output | 1 | Memory clock, held low |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_cre | output | 1 | Configuration register enable |
| mem_addr_hi | output | 8 | Upper address bits |
| mem_adq_o | output | 16 | Shared bus output value |
| mem_adq_oe | output | 1 | Shared bus output drive enable |
| mem_adq_i | input | 16 | Shared bus input value |

## Verification
The assertions watch the pin protocol on every clock. They check that address-valid is low only with the chip selected and the bus driven, and that the address is held across the address-valid rise. They also check that output and write enables are mutually exclusive, that output enable never overlaps or directly follows bus drive, and that the upper address and config enable stay steady while selected. Only the bench scenarios can show the data-level results: readback of full and partial-lane writes, configuration load and readback, the exact phase counts and done latency, and that a request raised mid-access is dropped. These are checked against a pin-level memory model fed by random and directed requests.

// File: rtl/amux_psram_pkg.sv
package amux_psram_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int HI_W   = ADDR_W - DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LATCH,
        ST_DATA,
        ST_RECOVER,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic              write;
        logic              cfg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
    } xfer_req_t;

    typedef struct packed {
        logic              ce_n;
        logic              adv_n;
        logic              oe_n;
        logic              we_n;
        logic              cre;
        logic              adq_oe;
        logic [LANES-1:0]  be_n;
        logic [HI_W-1:0]   addr_hi;
        logic [DATA_W-1:0] adq_o;
    } pin_bundle_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/amux_phase_timer.sv
module amux_phase_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/amux_seq_fsm.sv
module amux_seq_fsm
    import amux_psram_pkg::*;
#(
    parameter int ADDR_CYC = 2,
    parameter int DATA_CYC = 3,
    parameter int REC_CYC  = 2,
    parameter int CNT_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  xfer_req_t         req_in,
    input  logic [DATA_W-1:0] adq_in,
    input  logic              tmr_expired,
    output seq_state_e        state,
    output xfer_req_t         req_q,
    output logic              turn,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic [DATA_W-1:0] rdata
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                state_d  = ST_ADDR;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(ADDR_CYC - 1);
            end
            ST_ADDR: if (tmr_expired) begin
                state_d  = ST_LATCH;
                tmr_load = 1'b1;
            end
            ST_LATCH: begin
                state_d  = ST_DATA;
                tmr_load = 1'b1;
                // a read spends one extra clock with the bus released
                tmr_val  = req_q.write ? CNT_W'(DATA_CYC - 1) : CNT_W'(DATA_CYC);
            end
            ST_DATA: if (tmr_expired) begin
                state_d  = ST_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(REC_CYC - 1);
            end
            ST_RECOVER: if (tmr_expired) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            turn    <= 1'b0;
            rdata   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid)
                req_q <= req_in;
            turn <= (state_q == ST_LATCH) && !req_q.write;
            if (state_q == ST_DATA && tmr_expired && !req_q.write)
                rdata <= adq_in;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/amux_pin_map.sv
module amux_pin_map
    import amux_psram_pkg::*;
(
    input  seq_state_e  state,
    input  xfer_req_t   req_q,
    input  logic        turn,
    output pin_bundle_t pins,
    output logic        done
);
    logic in_addr, in_latch, in_data, selected;

    assign in_addr  = (state == ST_ADDR);
    assign in_latch = (state == ST_LATCH);
    assign in_data  = (state == ST_DATA);
    assign selected = in_addr | in_latch | in_data;

    assign pins.ce_n    = !selected;
    assign pins.adv_n   = !in_addr;
    assign pins.we_n    = !(in_data && req_q.write);
    assign pins.oe_n    = !(in_data && !req_q.write && !turn);
    assign pins.cre     = selected && req_q.cfg;
    assign pins.adq_oe  = in_addr | in_latch | (in_data && req_q.write);
    assign pins.adq_o   = (in_addr | in_latch) ? req_q.addr[DATA_W-1:0] : req_q.wdata;
    assign pins.addr_hi = req_q.addr[ADDR_W-1:DATA_W];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign pins.be_n[g] = !(selected && req_q.be[g]);
    end

    assign done = (state == ST_DONE);
endmodule

// File: rtl/amux_psram_ctrl.sv
module amux_psram_ctrl
    import amux_psram_pkg::*;
#(
    parameter int ADDR_CYC = 2,
    parameter int DATA_CYC = 3,
    parameter int REC_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_cfg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              mem_clk,
    output logic              mem_ce_n,
    output logic              mem_adv_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic              mem_cre,
    output logic [HI_W-1:0]   mem_addr_hi,
    output logic [DATA_W-1:0] mem_adq_o,
    output logic              mem_adq_oe,
    input  logic [DATA_W-1:0] mem_adq_i
);
    localparam int CNT_W = $clog2(max3(ADDR_CYC, DATA_CYC + 1, REC_CYC) + 1);

    xfer_req_t   req_in, req_q;
    seq_state_e  state;
    logic        turn, tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    pin_bundle_t pins;

    assign req_in = '{write: req_write, cfg: req_cfg, addr: req_addr,
                      wdata: req_wdata, be: req_be};

    amux_phase_timer #(.W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    amux_seq_fsm #(
        .ADDR_CYC (ADDR_CYC),
        .DATA_CYC (DATA_CYC),
        .REC_CYC  (REC_CYC),
        .CNT_W    (CNT_W)
    ) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_in      (req_in),
        .adq_in      (mem_adq_i),
        .tmr_expired (tmr_expired),
        .state       (state),
        .req_q       (req_q),
        .turn        (turn),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .rdata       (rsp_rdata)
    );

    amux_pin_map i_pins (
        .state (state),
        .req_q (req_q),
        .turn  (turn),
        .pins  (pins),
        .done  (rsp_done)
    );

    assign mem_clk     = 1'b0;
    assign mem_ce_n    = pins.ce_n;
    assign mem_adv_n   = pins.adv_n;
    assign mem_oe_n    = pins.oe_n;
    assign mem_we_n    = pins.we_n;
    assign mem_lb_n    = pins.be_n[0];
    assign mem_ub_n    = pins.be_n[1];
    assign mem_cre     = pins.cre;
    assign mem_addr_hi = pins.addr_hi;
    assign mem_adq_o   = pins.adq_o;
    assign mem_adq_oe  = pins.adq_oe;
endmodule

// File: rtl/amux_psram_ctrl_chk.sv
module amux_psram_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        rsp_done,
    input logic        mem_ce_n,
    input logic        mem_adv_n,
    input logic        mem_oe_n,
    input logic        mem_we_n,
    input logic        mem_cre,
    input logic [7:0]  mem_addr_hi,
    input logic [15:0] mem_adq_o,
    input logic        mem_adq_oe
);
    assert_adv_selected_R1: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |-> (!mem_ce_n && mem_adq_oe));

    assert_hi_steady_R1: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr_hi));

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_adv_n) && !mem_ce_n) |-> (mem_adq_oe && $stable(mem_adq_o)));

    assert_enable_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    assert_strobe_after_adv_R4: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> (mem_adv_n && !mem_ce_n));

    assert_release_first_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_adq_oe && !$past(mem_adq_oe)));

    assert_cre_steady_R6: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_cre));

    assert_done_deselect_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
endmodule

bind amux_psram_ctrl amux_psram_ctrl_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .rsp_done    (rsp_done),
    .mem_ce_n    (mem_ce_n),
    .mem_adv_n   (mem_adv_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_cre     (mem_cre),
    .mem_addr_hi (mem_addr_hi),
    .mem_adq_o   (mem_adq_o),
    .mem_adq_oe  (mem_adq_oe)
);

// File: tb/test_amux_psram_ctrl.sv
module test_amux_psram_ctrl;
    localparam int A_CYC = 2;
    localparam int D_CYC = 3;
    localparam int R_CYC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_cfg = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] rsp_rdata, mem_adq_o;
    logic        rsp_done, mem_clk, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n;
    logic        mem_lb_n, mem_ub_n, mem_cre, mem_adq_oe;
    logic [7:0]  mem_addr_hi;
    logic [15:0] mem_adq_i = '0;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] pin_mem [logic [23:0]];
    logic [15:0] exp_mem [logic [23:0]];
    logic [23:0] pin_cfg = '0;
    logic [23:0] exp_cfg = '0;
    int          adv_rises = 0;

    always #5 clk = ~clk;

    amux_psram_ctrl #(.ADDR_CYC(A_CYC), .DATA_CYC(D_CYC), .REC_CYC(R_CYC)) i_amux_psram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_cfg(req_cfg), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_clk(mem_clk),
        .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_cre(mem_cre), .mem_addr_hi(mem_addr_hi), .mem_adq_o(mem_adq_o),
        .mem_adq_oe(mem_adq_oe), .mem_adq_i(mem_adq_i)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] be);
        return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
    endfunction

    function automatic logic [15:0] exp_word(input logic [23:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] pin_word(input logic [23:0] a);
        return pin_mem.exists(a) ? pin_mem[a] : 16'h0000;
    endfunction

    task automatic access(input logic w, input logic c, input logic [23:0] a,
                          input logic [15:0] d, input logic [1:0] be, input bit poke);
        int          n = 0, adv_cnt = 0, we_cnt = 0, oe_cnt = 0;
        logic        prev_adv = 1'b1;
        logic [15:0] prev_adq = '0;
        logic [23:0] lat = '0;
        logic        got_lat = 1'b0, bad_cre = 1'b0, bad_be = 1'b0;
        logic [15:0] exp_rd;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_cfg = c;
        req_addr = a; req_wdata = d; req_be = be;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            req_valid = 1'b0;
            if (poke && n == 3) begin
                req_valid = 1'b1; req_write = 1'b0; req_cfg = 1'b0; req_addr = a ^ 24'h000F0F;
            end
            if (!mem_ce_n) begin
                if (mem_cre !== c) bad_cre = 1'b1;
                if ({mem_ub_n, mem_lb_n} !== ~be) bad_be = 1'b1;
            end
            if (!mem_adv_n) adv_cnt++;
            if (prev_adv == 1'b0 && mem_adv_n == 1'b1 && !mem_ce_n) begin
                adv_rises++;
                got_lat = 1'b1;
                lat = {mem_addr_hi, prev_adq};
                check("R2", "address held at adv rise", {15'd0, mem_adq_oe, mem_adq_o},
                      {15'd0, 1'b1, prev_adq});
            end
            if (!mem_we_n && !mem_ce_n) begin
                we_cnt++;
                if (mem_cre) pin_cfg = lat;
                else pin_mem[lat] = merge(pin_word(lat), mem_adq_o, {~mem_ub_n, ~mem_lb_n});
            end
            if (!mem_oe_n && !mem_ce_n) begin
                oe_cnt++;
                mem_adq_i = mem_cre ? pin_cfg[15:0] : pin_word(lat);
            end else begin
                mem_adq_i = 16'h0000;
            end
            prev_adv = mem_adv_n;
            prev_adq = mem_adq_o;
            if (rsp_done) break;
            if (n > 80) begin
                check("R7", "access watchdog", 32'(n), 32'd0);
                break;
            end
        end
        check("R7", "done latency", 32'(n), 32'(2 + A_CYC + D_CYC + R_CYC + (w ? 0 : 1)));
        check("R1", "adv low cycles", 32'(adv_cnt), 32'(A_CYC));
        check("R1", "latched address", {7'd0, got_lat, lat}, {7'd0, 1'b1, a});
        check("R6", "cre during access", {31'd0, bad_cre}, 32'd0);
        check("R3", "byte enables", {31'd0, bad_be}, 32'd0);
        if (w) begin
            check("R3", "we low cycles", 32'(we_cnt), 32'(D_CYC));
            check("R4", "oe stays high on write", 32'(oe_cnt), 32'd0);
            if (c) exp_cfg = a;
            else exp_mem[a] = merge(exp_word(a), d, be);
        end else begin
            check("R4", "oe low cycles", 32'(oe_cnt), 32'(D_CYC));
            check("R4", "we stays high on read", 32'(we_cnt), 32'd0);
            exp_rd = c ? exp_cfg[15:0] : exp_word(a);
            check(c ? "R6" : "R5", "read data", {16'd0, rsp_rdata}, {16'd0, exp_rd});
        end
        @(negedge clk);
        check("R7", "done one cycle, chip deselected", {30'd0, rsp_done, mem_ce_n}, 32'd1);
    endtask

    initial begin
        int pre;
        logic [23:0] pool [6];
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "reset pin state",
              {23'd0, mem_clk, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n,
               mem_adq_oe, rsp_done},
              {23'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
        check("R5", "reset read data", {16'd0, rsp_rdata}, 32'd0);

        // R3 R5: full write then readback
        access(1'b1, 1'b0, 24'h123456, 16'hA5C3, 2'b11, 1'b0);
        access(1'b0, 1'b0, 24'h123456, 16'h0000, 2'b11, 1'b0);
        // R3: lane-gated writes
        access(1'b1, 1'b0, 24'h123456, 16'hFFEE, 2'b01, 1'b0);
        access(1'b0, 1'b0, 24'h123456, 16'h0000, 2'b11, 1'b0);
        check("R3", "low lane only", {16'd0, rsp_rdata}, 32'h0000A5EE);
        access(1'b1, 1'b0, 24'h123456, 16'h7711, 2'b10, 1'b0);
        access(1'b0, 1'b0, 24'h123456, 16'h0000, 2'b11, 1'b0);
        check("R3", "high lane only", {16'd0, rsp_rdata}, 32'h000077EE);
        // R6: configuration write from address lines, then readback
        access(1'b1, 1'b1, 24'h0A1B2C, 16'h9999, 2'b11, 1'b0);
        check("R6", "config register loaded", {8'd0, pin_cfg}, 32'h000A1B2C);
        access(1'b0, 1'b1, 24'h000000, 16'h0000, 2'b11, 1'b0);
        check("R6", "config read", {16'd0, rsp_rdata}, 32'h00001B2C);
        // R5: held read data after a write
        held = rsp_rdata;
        access(1'b1, 1'b0, 24'hFF0001, 16'h0F0F, 2'b11, 1'b0);
        check("R5", "read data held over write", {16'd0, rsp_rdata}, {16'd0, held});
        // R8: request raised mid-access is dropped
        pre = adv_rises;
        access(1'b1, 1'b0, 24'h00BEEF, 16'h5A5A, 2'b11, 1'b1);
        begin
            int extra = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!mem_ce_n || !mem_adv_n || rsp_done) extra++;
            end
            check("R8", "no access from busy request", 32'(extra), 32'd0);
            check("R8", "single address phase", 32'(adv_rises - pre), 32'd1);
            check("R9", "idle bus released", {31'd0, mem_adq_oe}, 32'd0);
        end
        // random mix over a small address pool
        void'($urandom(32'd5150));
        for (int i = 0; i < 6; i++) pool[i] = 24'($urandom);
        for (int i = 0; i < 60; i++) begin
            logic [23:0] a = pool[$urandom % 6];
            if ($urandom % 2)
                access(1'b1, 1'b0, a, 16'($urandom), 2'($urandom % 3 + 1), 1'b0);
            else
                access(1'b0, 1'b0, a, 16'h0000, 2'b11, 1'b0);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R7 global watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule